// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a double-data-rate SDRAM. It drives the command pins through the start-up procedure the memory needs before it can take ordinary traffic. While reset is active or the supply is not yet reported good, clock enable stays low and the command bus shows NOP. The `pwr_ok` input counts as stable only after it has been high for `T_STABLE` consecutive cycles. The block then holds NOP for `T_NOP` more cycles and raises clock enable.

After that it issues a fixed command list: precharge-all, extended mode write with the DLL enabled, and a mode write that resets the DLL. A second precharge-all follows, then `N_REF` auto-refreshes, then a final mode write that clears the DLL-reset bit. Each command is followed by exactly its minimum gap of NOPs. A separate DLL lock timer starts at the DLL-reset write. `init_done` rises only when the final mode write has had its gap and the lock time has also elapsed.

After a clock frequency change, the system pulses `reinit_req` while `init_done` is high. The block then repeats the DLL reset path and waits for a fresh lock time. A low `pwr_ok` at any time drops clock enable and starts the whole procedure again.

The FSM states are:
- S_PWRWAIT: counts power-stable cycles.
- S_NOPLOW: NOP with clock enable low.
- S_CKEUP: one NOP cycle with clock enable high.
- Command states, each lasting one cycle: S_PREA1, S_EMRS, S_MRSDLL, S_PREA2, S_REF, S_MRSOP.
- S_GAP: shared NOP wait that ends in a return state.
- S_LOCK: waits for the DLL lock.
- S_DONE: ready.

The FSM transitions are:
- pwr_stable: S_PWRWAIT to S_NOPLOW.
- nop_elapsed: S_NOPLOW to S_CKEUP.
- cke_settled: S_CKEUP to S_PREA1.
- cmd_issued: any command state to S_GAP.
- gap_elapsed: S_GAP to its return state. The return state after S_PREA1 is S_EMRS, or S_MRSDLL when re-initializing. The repeated refresh returns to S_REF until the last one, which returns to S_MRSOP.
- lock_seen: S_LOCK to S_DONE.
- reinit: S_DONE to S_PREA1.
- power_lost: any state to S_PWRWAIT.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: While rst_n is low: cke is 0, the command bus shows NOP, and init_done is 0.
- R2: cke stays 0 with NOP until pwr_ok has been high for T_STABLE consecutive cycles, and any low cycle restarts the count. NOP then holds for T_NOP cycles with cke low. cke rises exactly T_STABLE+T_NOP cycles after the first high cycle of the run.
- R3: Command codes are given as {cs_n,ras_n,cas_n,we_n}:
  - NOP is 0111.
  - Precharge-all is 0010, with addr bit 10 = 1, all other addr bits 0, and ba 00.
  - Auto-refresh is 0001, with addr and ba 0.
  - Mode write is 0000, with ba 00 for the standard register or ba 01 for the extended one.
  - The extended write carries EMODE_VAL with bit 0 cleared (DLL enabled).
  - The DLL-reset write carries MODE_VAL with bit 8 set.
  - The final write carries MODE_VAL with bit 8 cleared.
- R4: After one NOP cycle with cke high, the block issues these commands and no others, in this order: precharge-all, extended write, DLL-reset write, precharge-all, N_REF refreshes, final write.
- R5: The next command comes exactly T_RP cycles after a precharge, T_MRD cycles after a mode write, and T_RFC cycles after a refresh, with NOP in between.
- R6: init_done rises exactly one cycle after the later of two points: the final write plus T_MRD, and the DLL-reset write plus T_DLL. cke is 1 whenever init_done is 1.
- R7: When pwr_ok is low, on the next cycle cke is 0, the bus shows NOP, and init_done is 0. The full procedure of R2 and R4 then restarts.
- R8: reinit_req while init_done is 1 clears init_done on the next cycle. The block then issues precharge-all, DLL-reset write, precharge-all, N_REF refreshes and final write, with no extended write, using R5 spacing and R6 timing.
- R9: reinit_req has no effect while init_done is 0. When it arrives in the same cycle as a low pwr_ok, power loss wins and no command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_ok | input | 1 | Supply and clock reported stable |
| reinit_req | input | 1 | Request a DLL reset after a frequency change |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Device ready for normal traffic |

## Verification
Two events can land in the same cycle: a re-initialization request and a loss of power. The bench raises both in the same cycle while the device is ready. It then checks that clock enable is low and init_done is clear one cycle later, and that the scoreboard, whose queue is empty at that point, sees no precharge. It also pulses the request during the power wait and again in the middle of a sequence. In those cases the scoreboard must still see the full command list, extended write included, at exact spacing.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    typedef enum logic [3:0] {
        S_PWRWAIT,
        S_NOPLOW,
        S_CKEUP,
        S_PREA1,
        S_EMRS,
        S_MRSDLL,
        S_PREA2,
        S_REF,
        S_MRSOP,
        S_GAP,
        S_LOCK,
        S_DONE
    } seq_state_e;

    typedef logic [3:0] cmd_t;   // {cs_n, ras_n, cas_n, we_n}

    localparam cmd_t CMD_NOP = 4'b0111;
    localparam cmd_t CMD_PRE = 4'b0010;
    localparam cmd_t CMD_REF = 4'b0001;
    localparam cmd_t CMD_MRS = 4'b0000;

    localparam logic [1:0] BA_STD = 2'b00;
    localparam logic [1:0] BA_EXT = 2'b01;

    localparam int A_ALLBANK = 10;
    localparam int A_DLLRST  = 8;
    localparam int A_DLLDIS  = 0;

endpackage

// File: rtl/ddr_init_tmr.sv
module ddr_init_tmr #(
    parameter int W = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_VAL;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/ddr_init_lock.sv
module ddr_init_lock #(
    parameter int T_DLL = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic start,
    output logic locked
);

    localparam int LW = $clog2(T_DLL + 1);

    logic [LW-1:0] cnt_q;
    logic          armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (start) begin
            cnt_q   <= LW'(1);
            armed_q <= 1'b1;
        end else if (armed_q && cnt_q != LW'(T_DLL)) begin
            cnt_q <= cnt_q + LW'(1);
        end
    end

    assign locked = armed_q && (cnt_q == LW'(T_DLL));

endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
    import ddr_init_pkg::*;
#(
    parameter int T_STABLE = 20000,
    parameter int T_NOP    = 4,
    parameter int T_RP     = 3,
    parameter int T_MRD    = 2,
    parameter int T_RFC    = 9,
    parameter int T_DLL    = 200,
    parameter int N_REF    = 2,
    parameter int ADDR_W   = 13,
    parameter logic [ADDR_W-1:0] MODE_VAL  = ADDR_W'('h163),
    parameter logic [ADDR_W-1:0] EMODE_VAL = ADDR_W'('h003)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic              reinit_req,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    localparam int ST_W    = $clog2(T_STABLE + 1);
    localparam int GAP_M1  = (T_RP  > T_MRD)  ? T_RP  : T_MRD;
    localparam int GAP_M2  = (T_RFC > T_NOP)  ? T_RFC : T_NOP;
    localparam int GAP_MAX = (GAP_M1 > GAP_M2) ? GAP_M1 : GAP_M2;
    localparam int GAP_W   = $clog2(GAP_MAX + 1);
    localparam int REF_W   = $clog2(N_REF + 1);

    localparam logic [ADDR_W-1:0] AP_BIT  = ADDR_W'(1) << A_ALLBANK;
    localparam logic [ADDR_W-1:0] DLL_BIT = ADDR_W'(1) << A_DLLRST;
    localparam logic [ADDR_W-1:0] DIS_BIT = ADDR_W'(1) << A_DLLDIS;

    seq_state_e        state_q, state_d, ret_q, ret_d;
    logic [REF_W-1:0]  ref_q;
    logic              redo_q;
    logic              gap_load, gap_zero;
    logic [GAP_W-1:0]  gap_val;
    logic              st_load, st_zero;
    logic              dll_locked;
    cmd_t              cmd;

    // power-stable interval counter
    assign st_load = (state_q != S_PWRWAIT) || !pwr_ok;

    ddr_init_tmr #(.W(ST_W), .RST_VAL(ST_W'(T_STABLE - 1))) u_stable_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (st_load),
        .load_val (ST_W'(T_STABLE - 1)),
        .zero     (st_zero)
    );

    // shared command-gap counter
    ddr_init_tmr #(.W(GAP_W), .RST_VAL('0)) u_gap_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .zero     (gap_zero)
    );

    // DLL lock interval, running alongside the rest of the sequence
    ddr_init_lock #(.T_DLL(T_DLL)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state_q == S_PWRWAIT),
        .start  (state_q == S_MRSDLL),
        .locked (dll_locked)
    );

    // next-state logic
    always_comb begin
        state_d  = state_q;
        ret_d    = ret_q;
        gap_load = 1'b0;
        gap_val  = '0;
        unique case (state_q)
            S_PWRWAIT: if (pwr_ok && st_zero) begin
                state_d  = S_NOPLOW;
                gap_load = 1'b1;
                gap_val  = GAP_W'(T_NOP - 1);
            end
            S_NOPLOW:  if (gap_zero) state_d = S_CKEUP;
            S_CKEUP:   state_d = S_PREA1;
            S_PREA1: begin
                state_d  = S_GAP;
                ret_d    = redo_q ? S_MRSDLL : S_EMRS;
                gap_load = 1'b1;
                gap_val  = GAP_W'(T_RP - 2);
            end
            S_EMRS: begin
                state_d  = S_GAP;
                ret_d    = S_MRSDLL;
                gap_load = 1'b1;
                gap_val  = GAP_W'(T_MRD - 2);
            end
            S_MRSDLL: begin
                state_d  = S_GAP;
                ret_d    = S_PREA2;
                gap_load = 1'b1;
                gap_val  = GAP_W'(T_MRD - 2);
            end
            S_PREA2: begin
                state_d  = S_GAP;
                ret_d    = S_REF;
                gap_load = 1'b1;
                gap_val  = GAP_W'(T_RP - 2);
            end
            S_REF: begin
                state_d  = S_GAP;
                ret_d    = (ref_q == REF_W'(N_REF - 1)) ? S_MRSOP : S_REF;
                gap_load = 1'b1;
                gap_val  = GAP_W'(T_RFC - 2);
            end
            S_MRSOP: begin
                state_d  = S_GAP;
                ret_d    = S_LOCK;
                gap_load = 1'b1;
                gap_val  = GAP_W'(T_MRD - 2);
            end
            S_GAP:     if (gap_zero) state_d = ret_q;
            S_LOCK:    if (dll_locked) state_d = S_DONE;
            S_DONE:    if (reinit_req) state_d = S_PREA1;
            default:   state_d = S_PWRWAIT;
        endcase
        if (!pwr_ok) state_d = S_PWRWAIT;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_PWRWAIT;
            ret_q   <= S_PWRWAIT;
            ref_q   <= '0;
            redo_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
            if (state_q == S_PREA2)
                ref_q <= '0;
            else if (state_q == S_REF)
                ref_q <= ref_q + REF_W'(1);
            if (state_q == S_PWRWAIT || state_q == S_LOCK)
                redo_q <= 1'b0;
            else if (state_q == S_DONE && reinit_req)
                redo_q <= 1'b1;
        end
    end

    // output decode
    always_comb begin
        cmd       = CMD_NOP;
        ba        = BA_STD;
        addr      = '0;
        cke       = 1'b1;
        init_done = 1'b0;
        unique case (state_q)
            S_PWRWAIT, S_NOPLOW: cke = 1'b0;
            S_PREA1, S_PREA2: begin
                cmd  = CMD_PRE;
                addr = AP_BIT;
            end
            S_EMRS: begin
                cmd  = CMD_MRS;
                ba   = BA_EXT;
                addr = EMODE_VAL & ~DIS_BIT;
            end
            S_MRSDLL: begin
                cmd  = CMD_MRS;
                addr = MODE_VAL | DLL_BIT;
            end
            S_REF:    cmd = CMD_REF;
            S_MRSOP: begin
                cmd  = CMD_MRS;
                addr = MODE_VAL & ~DLL_BIT;
            end
            S_DONE:   init_done = 1'b1;
            default: ;
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd;

endmodule

// File: rtl/ddr_pwrup_seq_chk.sv
module ddr_pwrup_seq_chk #(
    parameter int T_DLL  = 200,
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_ok,
    input logic              reinit_req,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [1:0]        ba,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done
);

    localparam int SW = $clog2(T_DLL + 2);

    logic [3:0]    cmd;
    logic          dll_wr;
    logic [SW-1:0] since_q;
    logic          seen_q;

    assign cmd    = {cs_n, ras_n, cas_n, we_n};
    assign dll_wr = cke && cmd == 4'b0000 && ba == 2'b00 && addr[8];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (dll_wr) begin
            since_q <= SW'(1);
            seen_q  <= 1'b1;
        end else if (since_q != SW'(T_DLL)) begin
            since_q <= since_q + SW'(1);
        end
    end

    // R7
    pwr_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (!cke && !init_done));

    // R2
    cke_low_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> cmd == 4'b0111);

    // R4
    cke_rise_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> cmd == 4'b0111);

    // R3
    prea_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0010) |-> addr[10]);

    // R5
    cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && cmd != 4'b0111) |=> cmd == 4'b0111);

    // R6
    done_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> cke);

    // R6
    dll_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (seen_q && since_q >= SW'(T_DLL)));

    // R8
    done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_done) |-> $past(!pwr_ok || reinit_req));

endmodule

bind ddr_pwrup_seq ddr_pwrup_seq_chk #(.T_DLL(T_DLL), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_ok     (pwr_ok),
    .reinit_req (reinit_req),
    .cke        (cke),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .ba         (ba),
    .addr       (addr),
    .init_done  (init_done)
);

// File: tb/test_ddr_pwrup_seq.sv
module test_ddr_pwrup_seq;

    localparam int T_STABLE = 60;
    localparam int T_NOP    = 4;
    localparam int T_RP     = 3;
    localparam int T_MRD    = 2;
    localparam int T_RFC    = 9;
    localparam int T_DLL    = 200;
    localparam int N_REF    = 2;
    localparam int ADDR_W   = 13;
    localparam logic [12:0] MODE_V  = 13'h163;
    localparam logic [12:0] EMODE_V = 13'h003;
    localparam logic [12:0] AP_B    = 13'h400;
    localparam logic [12:0] DLL_B   = 13'h100;
    localparam logic [3:0]  C_NOP   = 4'b0111;
    localparam logic [3:0]  C_PRE   = 4'b0010;
    localparam logic [3:0]  C_REF   = 4'b0001;
    localparam logic [3:0]  C_MRS   = 4'b0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok = 1'b0;
    logic reinit_req = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [1:0] ba;
    logic [ADDR_W-1:0] addr;

    always #5 clk = ~clk;

    ddr_pwrup_seq #(
        .T_STABLE(T_STABLE), .T_NOP(T_NOP), .T_RP(T_RP), .T_MRD(T_MRD),
        .T_RFC(T_RFC), .T_DLL(T_DLL), .N_REF(N_REF), .ADDR_W(ADDR_W),
        .MODE_VAL(MODE_V), .EMODE_VAL(EMODE_V)
    ) i_ddr_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .reinit_req(reinit_req),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .init_done(init_done)
    );

    typedef struct {
        logic [3:0]  code;
        logic [1:0]  ba;
        logic [12:0] addr;
        int          gap;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_evt = 0;
    int hi_run = 0;
    int dll_cyc = 0;
    int exp_done = -1;
    logic cke_prev = 1'b0;
    logic done_prev = 1'b0;
    logic lowbad = 1'b0;
    logic [3:0] mcmd;

    task automatic check(bit ok, string tag, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic push(logic [3:0] c, logic [1:0] b, logic [12:0] a, int g, string t);
        exp_t e;
        e.code = c; e.ba = b; e.addr = a; e.gap = g; e.tag = t;
        exp_q.push_back(e);
    endtask

    task automatic expect_init(bit redo, int first_gap, string tag);
        push(C_PRE, 2'b00, AP_B, first_gap, tag);
        if (!redo) begin
            push(C_MRS, 2'b01, EMODE_V & ~13'h001, T_RP, tag);
            push(C_MRS, 2'b00, MODE_V | DLL_B, T_MRD, tag);
        end else begin
            push(C_MRS, 2'b00, MODE_V | DLL_B, T_RP, tag);
        end
        push(C_PRE, 2'b00, AP_B, T_MRD, tag);
        for (int i = 0; i < N_REF; i++)
            push(C_REF, 2'b00, 13'h000, (i == 0) ? T_RP : T_RFC, tag);
        push(C_MRS, 2'b00, MODE_V & ~DLL_B, T_RFC, tag);
    endtask

    task automatic wait_done(string tag);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (init_done) break;
        end
        check(init_done == 1'b1, tag, "init_done reached", int'(init_done), 1);
    endtask

    // monitor: pops expected commands as the design produces them
    always @(negedge clk) begin
        cyc++;
        mcmd = {cs_n, ras_n, cas_n, we_n};
        if (!rst_n) begin
            hi_run = 0;
        end else begin
            hi_run = pwr_ok ? hi_run + 1 : 0;
            if (!cke && mcmd != C_NOP) lowbad = 1'b1;
            if (cke && !cke_prev) begin
                check(hi_run == T_STABLE + T_NOP + 1, "R2", "cke rise after stable run",
                      hi_run - 1, T_STABLE + T_NOP);
                check(!lowbad, "R2", "NOP while cke low", int'(lowbad), 0);
                check(mcmd == C_NOP, "R4", "NOP at cke rise", int'(mcmd), int'(C_NOP));
                lowbad = 1'b0;
                last_evt = cyc;
            end
            if (cke && mcmd != C_NOP) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected command", int'(mcmd), int'(C_NOP));
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(mcmd == e.code, e.tag, "command code", int'(mcmd), int'(e.code));
                    check(ba == e.ba, "R3", "bank address", int'(ba), int'(e.ba));
                    check(addr == e.addr, "R3", "address", int'(addr), int'(e.addr));
                    if (e.gap > 0)
                        check(cyc - last_evt == e.gap, "R5", "command spacing",
                              cyc - last_evt, e.gap);
                    if (mcmd == C_MRS && ba == 2'b00 && addr[8]) dll_cyc = cyc;
                    if (mcmd == C_MRS && ba == 2'b00 && !addr[8])
                        exp_done = ((cyc + T_MRD > dll_cyc + T_DLL) ?
                                    cyc + T_MRD : dll_cyc + T_DLL) + 1;
                end
                last_evt = cyc;
            end
            if (init_done && !done_prev) begin
                check(cyc == exp_done, "R6", "init_done rise cycle", cyc, exp_done);
                exp_done = -1;
            end
        end
        cke_prev = cke;
        done_prev = init_done;
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL R6 watchdog expired: actual 1 expected 0");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cke == 1'b0, "R1", "cke in reset", int'(cke), 0);
        check({cs_n, ras_n, cas_n, we_n} == C_NOP, "R1", "command in reset",
              int'({cs_n, ras_n, cas_n, we_n}), int'(C_NOP));
        check(init_done == 1'b0, "R1", "init_done in reset", int'(init_done), 0);
        @(posedge clk); #2 rst_n = 1'b1;

        // R2 / R9: power low, stray reinit ignored
        repeat (15) @(posedge clk);
        #2 reinit_req = 1'b1;
        @(posedge clk); #2 reinit_req = 1'b0;
        repeat (15) @(posedge clk);
        @(negedge clk);
        check(cke == 1'b0, "R2", "cke while power low", int'(cke), 0);
        check(init_done == 1'b0, "R9", "init_done after stray reinit", int'(init_done), 0);

        // R4: full sequence
        expect_init(1'b0, 1, "R4");
        @(posedge clk); #2 pwr_ok = 1'b1;
        wait_done("R6");
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R4", "all commands seen", exp_q.size(), 0);

        // R8: re-init after frequency change
        expect_init(1'b1, 0, "R8");
        @(posedge clk); #2 reinit_req = 1'b1;
        @(posedge clk); #2 reinit_req = 1'b0;
        @(negedge clk);
        check(init_done == 1'b0, "R8", "init_done after reinit", int'(init_done), 0);
        wait_done("R8");
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R8", "reinit commands seen", exp_q.size(), 0);

        // R9 / R7: power loss and reinit in the same cycle
        @(posedge clk); #2 begin pwr_ok = 1'b0; reinit_req = 1'b1; end
        @(posedge clk); #2 reinit_req = 1'b0;
        @(negedge clk);
        check(cke == 1'b0, "R9", "cke after simultaneous loss", int'(cke), 0);
        check(init_done == 1'b0, "R7", "init_done after power loss", int'(init_done), 0);
        check({cs_n, ras_n, cas_n, we_n} == C_NOP, "R9", "no command issued",
              int'({cs_n, ras_n, cas_n, we_n}), int'(C_NOP));
        repeat (10) @(posedge clk);

        // R7 / R9: loss mid-sequence, reinit pulse mid-sequence
        expect_init(1'b0, 1, "R7");
        @(posedge clk); #2 pwr_ok = 1'b1;
        while (exp_q.size() > 4) @(negedge clk);
        @(posedge clk); #2 reinit_req = 1'b1;
        @(posedge clk); #2 begin reinit_req = 1'b0; pwr_ok = 1'b0; end
        @(negedge clk); #1 exp_q.delete();
        @(negedge clk);
        check(cke == 1'b0, "R7", "cke after mid-sequence loss", int'(cke), 0);
        repeat (20) @(posedge clk);

        // R2: short power run then a glitch restarts the count
        #2 pwr_ok = 1'b1;
        repeat (20) @(posedge clk);
        #2 pwr_ok = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(cke == 1'b0, "R2", "cke after glitch", int'(cke), 0);
        expect_init(1'b0, 1, "R9");
        @(posedge clk); #2 pwr_ok = 1'b1;
        wait_done("R7");
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R4", "queue drained at end", exp_q.size(), 0);

        summary();
        $finish;
    end

endmodule